// File: doc/BRIEF.md
# Eight-Function ALU with Shared Adder

This block is an arithmetic/logic unit that produces eight results from two operands through one adder. A three-bit operation code selects addition, subtraction, increment, pass-through, bitwise AND, OR, XOR, or the complement of the first operand. Every bit position has a small conditioning cell in front of the adder. The cell rewrites the two adder operands from the raw bits and the code. A separate single-bit stage chooses the adder's carry-in.

Subtraction is formed by adding the inverted second operand with a carry-in of one. For increment, the second adder input is zero and the carry-in is one. For the four logic codes, the conditioning cell computes the bitwise result itself and places it on the first adder input. The second adder input and the carry-in are both zero, so the adder passes that result through unchanged. No wide output multiplexer is needed.

The adder's sum and carry-out are captured in an output register when the load enable is high. The operand width is a parameter and defaults to 8 bits.

Top module: `alu_ext_top`

## Requirements
- R1: While the active-low asynchronous reset is asserted, the registered result and carry are both zero.
- R2: Code 3'b000 loads result = (a + b) mod 2^WIDTH, and carry = bit WIDTH of a + b.
- R3: Code 3'b001 loads result = (a - b) mod 2^WIDTH, and carry = 1 exactly when a >= b (unsigned, so no borrow).
- R4: Code 3'b010 loads result = (a + 1) mod 2^WIDTH, and carry = 1 exactly when a is all ones.
- R5: Code 3'b011 loads result = a, and carry = 0.
- R6: Codes 3'b100, 3'b101 and 3'b110 load the bitwise AND, OR and XOR of a and b respectively.
- R7: Code 3'b111 loads the bitwise complement of a.
- R8: When en is low at a rising clock edge, result and carry keep their values, whatever op, a and b are.
- R9: Inputs present at a rising edge with en high appear on result and carry immediately after that edge (one register stage).
- R10: For every logic code (op bit 2 set), the adder sees a zero second operand and a zero carry-in, and the loaded carry is 0.
- R11: With WIDTH = 8, a = 8'b00001111 and b = 8'b00000101, codes 000 to 111 give 00010100, 00001010, 00010000, 00001111, 00000101, 00001111, 00001010 and 11110000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Load enable for the result register |
| op | input | 3 | Operation code {x,y,z} |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| result | output | WIDTH | Registered result |
| carry | output | 1 | Registered adder carry-out |

## Verification
The bench builds one copy at WIDTH = 4. On that copy, every operand pair under every code is swept: 2048 loads, each checked against plain integer arithmetic. This covers every carry and borrow boundary, including wrap at all ones, equal operands for subtraction, and zero. A second copy at the default WIDTH = 8 checks the eight stated results for the reference operand pair. Hold behaviour is exercised by changing all inputs while the enable is low.

// File: rtl/alu_ext_pkg.sv
package alu_ext_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_INC  = 3'b010,
    OP_PASS = 3'b011,
    OP_AND  = 3'b100,
    OP_OR   = 3'b101,
    OP_XOR  = 3'b110,
    OP_NOT  = 3'b111
  } alu_op_e;

  // First adder operand bit: raw bit for arithmetic, logic result otherwise
  function automatic logic cond_a_bit(alu_op_e op, logic a_i, logic b_i);
    case (op)
      OP_AND:  return a_i & b_i;
      OP_OR:   return a_i | b_i;
      OP_XOR:  return a_i ^ b_i;
      OP_NOT:  return ~a_i;
      default: return a_i;
    endcase
  endfunction

  // Second adder operand bit: only add and subtract use b
  function automatic logic cond_b_bit(alu_op_e op, logic b_i);
    case (op)
      OP_ADD:  return b_i;
      OP_SUB:  return ~b_i;
      default: return 1'b0;
    endcase
  endfunction

  // Carry-in: one for subtract (two's complement) and increment
  function automatic logic cond_cin(alu_op_e op);
    return (op == OP_SUB) || (op == OP_INC);
  endfunction

endpackage

// File: rtl/alu_ext_cell.sv
module alu_ext_cell
  import alu_ext_pkg::*;
(
  input  logic [2:0] op,
  input  logic       a_bit,
  input  logic       b_bit,
  output logic       ia_bit,
  output logic       ib_bit
);

  alu_op_e op_e;

  always_comb begin
    op_e   = alu_op_e'(op);
    ia_bit = cond_a_bit(op_e, a_bit, b_bit);
    ib_bit = cond_b_bit(op_e, b_bit);
  end

endmodule

// File: rtl/alu_cin_ext.sv
module alu_cin_ext
  import alu_ext_pkg::*;
(
  input  logic [2:0] op,
  output logic       cin
);

  always_comb cin = cond_cin(alu_op_e'(op));

endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             ci,
  output logic [WIDTH-1:0] s,
  output logic             co
);

  logic [WIDTH:0] c;

  assign c[0] = ci;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    assign s[i]   = x[i] ^ y[i] ^ c[i];
    assign c[i+1] = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
  end

  assign co = c[WIDTH];

endmodule

// File: rtl/alu_ext_top.sv
module alu_ext_top #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] result,
  output logic             carry
);

  // Named internal nets, observed by the bound checker
  logic [WIDTH-1:0] ia_w;
  logic [WIDTH-1:0] ib_w;
  logic             cin_w;
  logic [WIDTH-1:0] sum_w;
  logic             cout_w;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    alu_ext_cell u_cell (
      .op     (op),
      .a_bit  (a[i]),
      .b_bit  (b[i]),
      .ia_bit (ia_w[i]),
      .ib_bit (ib_w[i])
    );
  end

  alu_cin_ext u_cin (
    .op  (op),
    .cin (cin_w)
  );

  alu_ripple_adder #(.WIDTH(WIDTH)) u_add (
    .x  (ia_w),
    .y  (ib_w),
    .ci (cin_w),
    .s  (sum_w),
    .co (cout_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      carry  <= 1'b0;
    end else if (en) begin
      result <= sum_w;
      carry  <= cout_w;
    end
  end

endmodule

// File: rtl/alu_ext_chk.sv
module alu_ext_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [2:0]       op,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [WIDTH-1:0] result,
  input logic             carry,
  input logic [WIDTH-1:0] ia_w,
  input logic [WIDTH-1:0] ib_w,
  input logic             cin_w,
  input logic [WIDTH-1:0] sum_w
);

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(result) && $stable(carry)))
    else $error("hold violated"); // R8

  AST_LOAD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (result == $past(sum_w)))
    else $error("load mismatch"); // R9

  AST_LOGIC_ZERO_B: assert property (@(posedge clk) disable iff (!rst_n)
    op[2] |-> ((ib_w == '0) && !cin_w && (sum_w == ia_w)))
    else $error("logic path not clean"); // R10

  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op[2]) |=> !carry)
    else $error("carry on logic code"); // R10

  AST_INC_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 3'b010) |=> (result == WIDTH'($past(a) + 1'b1)))
    else $error("increment wrong"); // R4

  AST_PASS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 3'b011) |=> ((result == $past(a)) && !carry))
    else $error("pass wrong"); // R5

  AST_SUB_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 3'b001) |=> (carry == ($past(a) >= $past(b))))
    else $error("borrow wrong"); // R3

endmodule

bind alu_ext_top alu_ext_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en     (en),
  .op     (op),
  .a      (a),
  .b      (b),
  .result (result),
  .carry  (carry),
  .ia_w   (ia_w),
  .ib_w   (ib_w),
  .cin_w  (cin_w),
  .sum_w  (sum_w)
);

// File: tb/alu_ext_top_tb.sv
`timescale 1ns/1ps
module alu_ext_top_tb;

  localparam int W = 4;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [2:0]   op = 3'b000;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [W-1:0] result;
  logic         carry;

  logic         en8 = 1'b0;
  logic [2:0]   op8 = 3'b000;
  logic [7:0]   a8 = 8'h00;
  logic [7:0]   b8 = 8'h00;
  logic [7:0]   result8;
  logic         carry8;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  alu_ext_top #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .a(a), .b(b),
    .result(result), .carry(carry)
  );

  alu_ext_top u_dut8 (
    .clk(clk), .rst_n(rst_n), .en(en8), .op(op8), .a(a8), .b(b8),
    .result(result8), .carry(carry8)
  );

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected value from integer arithmetic
  function automatic void model(int code, int av, int bv, output int r, output int c);
    int s;
    c = 0;
    case (code)
      0: begin s = av + bv;     r = s & MAXV; c = (s >> W) & 1; end
      1: begin r = (av - bv) & MAXV; c = (av >= bv) ? 1 : 0; end
      2: begin s = av + 1;      r = s & MAXV; c = (av == MAXV) ? 1 : 0; end
      3: r = av;
      4: r = av & bv;
      5: r = av | bv;
      6: r = av ^ bv;
      default: r = (~av) & MAXV;
    endcase
  endfunction

  function automatic string tag(int code);
    case (code)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4, 5, 6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    int guard = 0;
    forever begin
      @(posedge clk);
      guard++;
      if (guard > 20000) begin
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", guard, 20000);
        finish_run();
      end
    end
  end

  initial begin
    int er, ec;
    int exp8 [8] = '{8'b00010100, 8'b00001010, 8'b00010000, 8'b00001111,
                     8'b00000101, 8'b00001111, 8'b00001010, 8'b11110000};
    // R1: reset state
    a = '1; b = '1; en = 1'b1; op = 3'b000;
    repeat (3) @(negedge clk);
    check("R1", result, 0, "result in reset");
    check("R1", carry, 0, "carry in reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R2..R7, R9, R10: exhaustive sweep at W=4
    for (int code = 0; code < 8; code++) begin
      for (int av = 0; av <= MAXV; av++) begin
        for (int bv = 0; bv <= MAXV; bv++) begin
          op = 3'(code); a = W'(av); b = W'(bv); en = 1'b1;
          @(negedge clk);
          model(code, av, bv, er, ec);
          check(tag(code), result, er, "result");
          if (code >= 4) check("R10", carry, 0, "logic carry");
          else check(tag(code), carry, ec, "carry");
        end
      end
    end

    // R9: one-stage latency, value appears right after the loading edge
    op = 3'b000; a = 4'd9; b = 4'd9; en = 1'b1;
    @(negedge clk);
    check("R9", result, 2, "result after one edge");
    check("R9", carry, 1, "carry after one edge");

    // R8: en low, all inputs change, state held
    en = 1'b0;
    for (int code = 0; code < 8; code++) begin
      op = 3'(code); a = W'(code * 3); b = W'(15 - code);
      @(negedge clk);
      check("R8", result, 2, "held result");
      check("R8", carry, 1, "held carry");
    end

    // R11: stated example at WIDTH 8
    a8 = 8'b00001111; b8 = 8'b00000101; en8 = 1'b1;
    for (int code = 0; code < 8; code++) begin
      op8 = 3'(code);
      @(negedge clk);
      check("R11", result8, exp8[code], "example result");
    end

    finish_run();
  end

endmodule